// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Stall Unit

This block sits beside the execute stage of a five-stage 32-bit pipeline. It tracks the register indices and write intent of the instructions in the decode, execute, memory and writeback stages. For each of the two execute operands it picks the right source, so that a dependent instruction sees the result of an older one without waiting for the register file. It holds the register file itself, with a write-through path so that decode reads return a value being written back in the same cycle. It also holds the small per-stage records needed for the bypass decisions.

The memory stage's ALU result can be bypassed directly, except when the instruction there is a load: its data only arrives at the end of the memory stage. In that case the unit raises `stall` for exactly one cycle. During that cycle it freezes the decode and execute records and sends an empty slot into the memory stage. The load itself keeps moving, so its value can be forwarded from writeback in the following cycle. The ALU and the data memory are outside the block: `ex_alu_res` returns the ALU output for the selected operands, and `mem_load_data` returns the memory word for `mem_addr`.

Decode hand-off is a valid/ready pair with `!stall` as ready. An instruction offered with `id_valid` high is taken at a rising edge only while `stall` is low. While `stall` is high the source must keep the same instruction on the `id_*` pins. Nothing is lost if `id_valid` is low, because that simply issues an empty slot.

Top module: `exu_fwd_hazard`

## Requirements
- R1: Select code 0 means register-file value, 1 means memory-stage ALU result, 2 means writeback value; code 3 never appears. With no match in memory or writeback the operand equals the architectural register value, and `mem_addr` equals the ALU result of the instruction now in the memory stage.
- R2: An operand whose index matches the writeback destination but not the memory-stage destination uses code 2 and the writeback value, which for a load is the loaded word.
- R3: An operand whose index matches the memory-stage destination uses code 1, even when writeback has the same destination.
- R4: Index 0 never forwards (code 0) and always reads as zero. A destination counts only when its instruction is valid and has `id_we` set; a load with destination 0 never stalls.
- R5: `stall` is high in exactly the cycles where the execute instruction is valid, the memory-stage instruction is a writing load with nonzero destination, and either execute source index equals that destination.
- R6: While `stall` is high the execute instruction is kept. In the next cycle the same instruction is in execute and takes the load's value from writeback (code 2), and the held decode instruction is taken at that edge.
- R7: The edge that ends a stall cycle loads an empty slot into the memory stage. `mem_bubble` is high in exactly the cycle after each stall cycle, and `stall` is never high two cycles running.
- R8: A decode read of a register that writeback writes at the same edge returns the new value.
- R9: If the stalled instruction's other operand was being supplied from writeback during the stall, that value survives the stall: operand values always equal the architectural values of program order.
- R10: While reset is active, `stall`, `mem_bubble` and both select codes are 0, and all registers read as zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode holds an instruction |
| id_rs1 | input | 5 | First source index at decode |
| id_rs2 | input | 5 | Second source index at decode |
| id_rd | input | 5 | Destination index at decode |
| id_we | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| ex_alu_res | input | 32 | ALU result for the current execute operands |
| mem_load_data | input | 32 | Data memory word for `mem_addr` |
| stall | output | 1 | Load-use hold; decode not ready |
| mem_bubble | output | 1 | Memory stage holds an injected empty slot |
| ex_sel_a | output | 2 | Source code of operand A |
| ex_sel_b | output | 2 | Source code of operand B |
| ex_opnd_a | output | 32 | Selected operand A |
| ex_opnd_b | output | 32 | Selected operand B |
| mem_addr | output | 32 | Memory-stage ALU result, used as load address |

## Verification
The bench goes after stalls in which the stalled instruction's other operand is being supplied from writeback during the stall. A design that freezes the raw decode-time value would return a stale operand one cycle later. It drives loads whose destination is register 0 and writes with `id_we` clear. It also places loads and empty slots two stages ahead of a reader. A design that ignored write intent or validity would stall or forward where it must not. Chains of back-to-back dependents check memory-over-writeback priority, and a reader placed three instructions behind a writer exposes a missing decode write-through. After every load-use stall the bench checks for a second stall, which a design that repeated the memory-stage instruction would raise forever.

// File: rtl/exu_fwd_pkg.sv
package exu_fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/rf_wr_bypass.sv
// Register file with write-through reads: a read of the index being written
// back at this edge returns the incoming value. Index 0 reads as zero.
module rf_wr_bypass #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RIDX-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [RIDX-1:0] rd_idx  [NRD],
  output logic [XLEN-1:0] rd_data [NRD]
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en && (wr_idx != '0)) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] == '0)
        rd_data[p] = '0;
      else if (wr_en && (wr_idx == rd_idx[p]))
        rd_data[p] = wr_data;
      else
        rd_data[p] = regs_q[rd_idx[p]];
    end
  end
endmodule

// File: rtl/opnd_src_pick.sv
// One execute operand: memory stage beats writeback, writeback beats the
// value captured at decode. Index 0 never matches.
module opnd_src_pick
  import exu_fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] src_idx,
  input  logic [XLEN-1:0] rf_val,
  input  logic            mem_wr,
  input  logic [RIDX-1:0] mem_dst,
  input  logic [XLEN-1:0] mem_val,
  input  logic            wb_wr,
  input  logic [RIDX-1:0] wb_dst,
  input  logic [XLEN-1:0] wb_val,
  output opnd_src_e       sel,
  output logic [XLEN-1:0] val,
  output logic            mem_hit
);
  logic live;
  logic wb_hit;

  assign live    = (src_idx != '0);
  assign mem_hit = live && mem_wr && (mem_dst == src_idx);
  assign wb_hit  = live && wb_wr && (wb_dst == src_idx);

  always_comb begin
    if (mem_hit) begin
      sel = SRC_MEM;
      val = mem_val;
    end else if (wb_hit) begin
      sel = SRC_WB;
      val = wb_val;
    end else begin
      sel = SRC_RF;
      val = rf_val;
    end
  end
endmodule

// File: rtl/load_use_detect.sv
// Stall when a valid execute instruction needs the destination of a writing
// load that is still in the memory stage.
module load_use_detect #(
  parameter int NOPND = 2
) (
  input  logic             ex_valid,
  input  logic             mem_ld_wr,
  input  logic [NOPND-1:0] mem_hit,
  output logic             stall
);
  assign stall = ex_valid && mem_ld_wr && (|mem_hit);
endmodule

// File: rtl/exu_fwd_hazard.sv
module exu_fwd_hazard
  import exu_fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic [RIDX-1:0] id_rs1,
  input  logic [RIDX-1:0] id_rs2,
  input  logic [RIDX-1:0] id_rd,
  input  logic            id_we,
  input  logic            id_load,
  input  logic [XLEN-1:0] ex_alu_res,
  input  logic [XLEN-1:0] mem_load_data,
  output logic            stall,
  output logic            mem_bubble,
  output logic [1:0]      ex_sel_a,
  output logic [1:0]      ex_sel_b,
  output logic [XLEN-1:0] ex_opnd_a,
  output logic [XLEN-1:0] ex_opnd_b,
  output logic [XLEN-1:0] mem_addr
);
  localparam int NOPND = 2;

  // decode
  logic [RIDX-1:0] id_rs [NOPND];
  logic [XLEN-1:0] id_rv [NOPND];
  // execute record
  logic            ex_valid, ex_we, ex_load;
  logic [RIDX-1:0] ex_rd;
  logic [RIDX-1:0] ex_rs [NOPND];
  logic [XLEN-1:0] ex_rv [NOPND];
  // memory record
  logic            mem_valid, mem_we, mem_load;
  logic [RIDX-1:0] mem_rd;
  logic [XLEN-1:0] mem_res;
  // writeback record
  logic            wb_we;
  logic [RIDX-1:0] wb_rd;
  logic [XLEN-1:0] wb_val;
  // bypass
  opnd_src_e        opnd_sel [NOPND];
  logic [XLEN-1:0]  opnd_val [NOPND];
  logic [NOPND-1:0] mem_hit;

  assign id_rs[0] = id_rs1;
  assign id_rs[1] = id_rs2;

  rf_wr_bypass #(.XLEN(XLEN), .NREG(NREG), .NRD(NOPND)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wb_we),
    .wr_idx  (wb_rd),
    .wr_data (wb_val),
    .rd_idx  (id_rs),
    .rd_data (id_rv)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    opnd_src_pick #(.XLEN(XLEN), .RIDX(RIDX)) u_pick (
      .src_idx (ex_rs[g]),
      .rf_val  (ex_rv[g]),
      .mem_wr  (mem_we),
      .mem_dst (mem_rd),
      .mem_val (mem_res),
      .wb_wr   (wb_we),
      .wb_dst  (wb_rd),
      .wb_val  (wb_val),
      .sel     (opnd_sel[g]),
      .val     (opnd_val[g]),
      .mem_hit (mem_hit[g])
    );
  end

  load_use_detect #(.NOPND(NOPND)) u_luse (
    .ex_valid  (ex_valid),
    .mem_ld_wr (mem_we && mem_load),
    .mem_hit   (mem_hit),
    .stall     (stall)
  );

  // Execute record: holds through a stall, but its operand values are
  // refreshed from the bypass so a value leaving writeback is not lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_we    <= 1'b0;
      ex_load  <= 1'b0;
      ex_rd    <= '0;
      for (int k = 0; k < NOPND; k++) begin
        ex_rs[k] <= '0;
        ex_rv[k] <= '0;
      end
    end else if (!stall) begin
      ex_valid <= id_valid;
      ex_we    <= id_valid && id_we;
      ex_load  <= id_valid && id_load;
      ex_rd    <= id_rd;
      for (int k = 0; k < NOPND; k++) begin
        ex_rs[k] <= id_rs[k];
        ex_rv[k] <= id_rv[k];
      end
    end else begin
      for (int k = 0; k < NOPND; k++) ex_rv[k] <= opnd_val[k];
    end
  end

  // Memory record: an empty slot enters on a stall, the load moves on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_load   <= 1'b0;
      mem_rd     <= '0;
      mem_res    <= '0;
      mem_bubble <= 1'b0;
    end else if (stall) begin
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_load   <= 1'b0;
      mem_bubble <= 1'b1;
    end else begin
      mem_valid  <= ex_valid;
      mem_we     <= ex_we;
      mem_load   <= ex_load;
      mem_rd     <= ex_rd;
      mem_res    <= ex_alu_res;
      mem_bubble <= 1'b0;
    end
  end

  // Writeback record: always advances.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_we  <= 1'b0;
      wb_rd  <= '0;
      wb_val <= '0;
    end else begin
      wb_we  <= mem_valid && mem_we;
      wb_rd  <= mem_rd;
      wb_val <= mem_load ? mem_load_data : mem_res;
    end
  end

  assign ex_sel_a  = opnd_sel[0];
  assign ex_sel_b  = opnd_sel[1];
  assign ex_opnd_a = opnd_val[0];
  assign ex_opnd_b = opnd_val[1];
  assign mem_addr  = mem_res;
endmodule

// File: rtl/exu_fwd_hazard_chk.sv
module exu_fwd_hazard_chk
  import exu_fwd_pkg::*;
#(
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            mem_bubble,
  input logic [1:0]      ex_sel_a,
  input logic [1:0]      ex_sel_b,
  input logic            ex_valid,
  input logic [RIDX-1:0] ex_rd,
  input logic [RIDX-1:0] ex_rs1,
  input logic [RIDX-1:0] ex_rs2
);
  a_r7_one_cycle_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r7_bubble_next: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> mem_bubble);

  a_r7_bubble_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mem_bubble |-> $past(stall));

  a_r6_ex_held: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(ex_valid) && $stable(ex_rd) && $stable(ex_rs1) && $stable(ex_rs2)));

  a_r5_stall_has_mem_src: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((ex_sel_a == SRC_MEM) || (ex_sel_b == SRC_MEM)));

  a_r4_x0_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_rs1 == '0) |-> (ex_sel_a == SRC_RF)) and ((ex_rs2 == '0) |-> (ex_sel_b == SRC_RF)));

  a_r1_sel_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a != 2'd3) && (ex_sel_b != 2'd3));
endmodule

bind exu_fwd_hazard exu_fwd_hazard_chk #(.RIDX(RIDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .mem_bubble (mem_bubble),
  .ex_sel_a   (ex_sel_a),
  .ex_sel_b   (ex_sel_b),
  .ex_valid   (ex_valid),
  .ex_rd      (ex_rd),
  .ex_rs1     (ex_rs[0]),
  .ex_rs2     (ex_rs[1])
);

// File: tb/exu_fwd_hazard_tb.sv
module exu_fwd_hazard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_valid;
  logic [4:0]  id_rs1, id_rs2, id_rd;
  logic        id_we, id_load;
  logic [31:0] ex_alu_res, mem_load_data;
  logic        stall, mem_bubble;
  logic [1:0]  ex_sel_a, ex_sel_b;
  logic [31:0] ex_opnd_a, ex_opnd_b, mem_addr;

  always #10 clk = ~clk;

  function automatic logic [31:0] alu_f(logic [31:0] a, logic [31:0] b);
    return ((a << 1) ^ b) + 32'h0000_1F3D;
  endfunction
  function automatic logic [31:0] mem_h(logic [31:0] x);
    return {x[15:0], ~x[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  assign ex_alu_res    = alu_f(ex_opnd_a, ex_opnd_b);
  assign mem_load_data = mem_h(mem_addr);

  exu_fwd_hazard u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rd(id_rd), .id_we(id_we), .id_load(id_load), .ex_alu_res(ex_alu_res),
    .mem_load_data(mem_load_data), .stall(stall), .mem_bubble(mem_bubble),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .ex_opnd_a(ex_opnd_a),
    .ex_opnd_b(ex_opnd_b), .mem_addr(mem_addr)
  );

  typedef struct packed {
    bit        v;
    bit [4:0]  rs1, rs2, rd;
    bit        we, ld;
    bit [31:0] ea, eb;
  } slot_t;

  slot_t       ex_s, mem_s, wb_s;
  bit [31:0]   arch [32];
  int          checks = 0, errors = 0, stalls_seen = 0;
  bit          prev_stall = 1'b0, prev_dut_stall = 1'b0, done = 1'b0;
  string       op_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [1:0] exp_sel(bit [4:0] rs);
    if (rs == 0) return 2'd0;
    if (mem_s.v && mem_s.we && mem_s.rd == rs) return 2'd1;
    if (wb_s.v && wb_s.we && wb_s.rd == rs) return 2'd2;
    return 2'd0;
  endfunction

  function automatic string sel_tag(bit [4:0] rs, bit [1:0] s);
    if (prev_stall) return "R6";
    if (rs == 0) return "R4";
    if (s == 2'd1) return "R3";
    if (s == 2'd2) return "R2";
    return "R1";
  endfunction

  // Check the current cycle at the falling edge, then advance the model
  // through the coming rising edge.
  task automatic tick(output bit took);
    bit es;
    bit [1:0] sa, sb;
    es = ex_s.v && mem_s.v && mem_s.we && mem_s.ld && (mem_s.rd != 0) &&
         ((ex_s.rs1 == mem_s.rd) || (ex_s.rs2 == mem_s.rd));
    chk("R5", "stall", {31'd0, stall}, {31'd0, es});
    chk("R7", "mem_bubble", {31'd0, mem_bubble}, {31'd0, prev_stall});
    if (stall && prev_dut_stall) chk("R7", "stall repeated", 32'd1, 32'd0);
    if (ex_s.v) begin
      sa = exp_sel(ex_s.rs1);
      sb = exp_sel(ex_s.rs2);
      chk(sel_tag(ex_s.rs1, sa), "sel_a", {30'd0, ex_sel_a}, {30'd0, sa});
      chk(sel_tag(ex_s.rs2, sb), "sel_b", {30'd0, ex_sel_b}, {30'd0, sb});
      if (!es) begin
        chk(prev_stall ? "R9" : op_tag, "opnd_a", ex_opnd_a, ex_s.ea);
        chk(prev_stall ? "R9" : op_tag, "opnd_b", ex_opnd_b, ex_s.eb);
      end
    end
    if (mem_s.v) chk("R1", "mem_addr", mem_addr, alu_f(mem_s.ea, mem_s.eb));
    if (es) stalls_seen++;
    prev_dut_stall = stall;
    prev_stall = es;
    wb_s = mem_s;
    if (es) begin
      mem_s = '0;
    end else begin
      mem_s = ex_s;
      ex_s  = '0;
      if (id_valid) begin
        bit [31:0] r;
        ex_s.v   = 1'b1;
        ex_s.rs1 = id_rs1; ex_s.rs2 = id_rs2; ex_s.rd = id_rd;
        ex_s.we  = id_we;  ex_s.ld  = id_load;
        ex_s.ea  = (id_rs1 == 0) ? 32'd0 : arch[id_rs1];
        ex_s.eb  = (id_rs2 == 0) ? 32'd0 : arch[id_rs2];
        r = alu_f(ex_s.ea, ex_s.eb);
        if (id_we && id_rd != 0) arch[id_rd] = id_load ? mem_h(r) : r;
      end
    end
    took = !es;
    @(negedge clk);
  endtask

  task automatic issue(bit v, bit [4:0] r1, bit [4:0] r2, bit [4:0] rd, bit we, bit ld);
    bit took;
    id_valid = v; id_rs1 = r1; id_rs2 = r2; id_rd = rd; id_we = we; id_load = ld;
    do tick(took); while (!took);
    id_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) arch[i] = '0;
    ex_s = '0; mem_s = '0; wb_s = '0;
    rst_n = 1'b0;
    id_valid = 1'b0; id_rs1 = '0; id_rs2 = '0; id_rd = '0; id_we = 1'b0; id_load = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "stall in reset", {31'd0, stall}, 32'd0);
    chk("R10", "bubble in reset", {31'd0, mem_bubble}, 32'd0);
    chk("R10", "sel_a in reset", {30'd0, ex_sel_a}, 32'd0);
    chk("R10", "sel_b in reset", {30'd0, ex_sel_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: untouched register reads zero
    op_tag = "R10";
    issue(1, 5'd7, 5'd9, 5'd0, 0, 0);
    issue(0, 0, 0, 0, 0, 0);

    // R3/R2: back-to-back dependent chain
    op_tag = "R3";
    issue(1, 0, 0, 5'd2, 1, 0);
    issue(1, 5'd1, 5'd2, 5'd1, 1, 0);
    issue(1, 5'd1, 5'd1, 5'd1, 1, 0);
    issue(1, 5'd1, 5'd2, 5'd1, 1, 0);

    // R5/R6/R7: load then two dependents
    op_tag = "R5";
    issue(1, 5'd2, 0, 5'd1, 1, 1);
    issue(1, 5'd1, 5'd1, 5'd1, 1, 0);
    issue(1, 5'd1, 5'd1, 5'd1, 1, 0);

    // R9: other operand in writeback during the stall
    op_tag = "R9";
    issue(1, 5'd1, 5'd2, 5'd3, 1, 0);
    issue(1, 5'd2, 0, 5'd4, 1, 1);
    issue(1, 5'd4, 5'd3, 5'd5, 1, 0);

    // R8: reader three behind writer relies on decode write-through
    op_tag = "R8";
    issue(1, 5'd5, 5'd1, 5'd6, 1, 0);
    issue(1, 0, 0, 5'd7, 1, 0);
    issue(1, 0, 0, 5'd8, 1, 0);
    issue(1, 5'd6, 5'd6, 5'd9, 1, 0);

    // R4: load to x0, non-writing instruction with matching rd
    op_tag = "R4";
    issue(1, 5'd1, 0, 5'd0, 1, 1);
    issue(1, 0, 0, 5'd10, 1, 0);
    issue(1, 5'd3, 5'd3, 5'd2, 0, 0);
    issue(1, 5'd2, 5'd2, 5'd11, 1, 0);

    // R2: load two ahead, and load followed by an empty slot
    op_tag = "R2";
    issue(1, 5'd2, 0, 5'd12, 1, 1);
    issue(1, 0, 0, 5'd13, 1, 0);
    issue(1, 5'd12, 5'd13, 5'd14, 1, 0);
    issue(1, 5'd14, 0, 5'd15, 1, 1);
    issue(0, 0, 0, 0, 0, 0);
    issue(1, 5'd15, 5'd15, 5'd16, 1, 0);

    // Random mix on a small register set
    op_tag = "R1";
    for (int n = 0; n < 3000; n++) begin
      bit [4:0] a, b, d;
      a = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 4);
      b = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 4);
      d = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 4);
      issue(($urandom % 100) < 85, a, b, d, ($urandom % 100) < 80, ($urandom % 100) < 30);
    end
    repeat (4) issue(0, 0, 0, 0, 0, 0);
    chk("R5", "stalls observed", {31'd0, (stalls_seen > 0)}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule